// File: doc/BRIEF.md
# CAN error flag and code capture unit

This block gathers the error events that a CAN protocol engine reports and turns them into one interrupt cause. Each event arrives as a single-cycle pulse. Error-factor events (bus errors, warning and passive transitions, bus-off entry and recovery, receive overrun, overload transmission, bus lock) set sticky bits in a flag byte. A matching enable byte selects which of those bits feed the error interrupt. Protocol error details (stuff, form, ACK, CRC, bit errors and ACK delimiter errors) are recorded in a separate error-code byte.

Software clears any flag or code bit by writing 0 to it. Writing 1 leaves the bit alone, so software clears a single bit by writing the inverse of its mask. The top bit of the code byte selects the display mode: either codes accumulate across errors, or only the most recent error pattern is kept. The transmit and receive error counts come from the engine and are offered as two read-only bytes. The error status output feeds bit 5 of the chip-level interrupt status, and an external enable gates it onto the interrupt line.

Top module: `can_err_capture`

## Requirements
- R1: After reset the flag, enable and code bytes read 0x00, and err_stat_o and irq_o are 0.
- R2: A pulse on flag_evt_i[k] sets bit k of the flag byte (address 0) on the next clock edge, and the bit stays set until software clears it. Bit layout from 7 down to 0: bus lock, overload sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R3: A write to address 0 clears every flag bit written as 0 and leaves every bit written as 1 unchanged.
- R4: When a flag event and a software clear hit the same bit in one cycle, the bit ends up set.
- R5: The enable byte at address 1 is plain read/write and uses the flag layout. err_stat_o is 1 exactly when some bit is set in both the flag byte and the enable byte.
- R6: irq_o equals err_stat_o ANDed with irq_en_i (the interrupt-enable bit 5).
- R7: The code byte is at address 2. Bits 6 down to 0 are ACK delimiter, dominant bit, recessive bit, CRC, ACK, form and stuff error, driven by code_evt_i[6:0]. Bit 7 is the display mode and takes the written value directly.
- R8: With the display mode at 1, a code event ORs its bits into bits 6:0.
- R9: With the display mode at 0, a code event replaces bits 6:0 with the event pattern. The mode used is the one stored before the edge.
- R10: Code bits 6:0 clear on a write of 0 and are unchanged on a write of 1. An event on the same bit in the same cycle wins over the clear.
- R11: Address 3 reads tec_i and address 4 reads rec_i. Writes to addresses 3 to 7 change nothing, and reads of addresses 5 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_evt_i | input | 8 | Error-factor event pulses |
| code_evt_i | input | 7 | Error-code event pulses |
| tec_i | input | 8 | Transmit error count from the engine |
| rec_i | input | 8 | Receive error count from the engine |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| irq_en_i | input | 1 | Interrupt-enable bit 5 |
| err_stat_o | output | 1 | Error interrupt status bit 5 |
| irq_o | output | 1 | Gated error interrupt |

## Verification
The assertions assume that a write is a one-cycle strobe with a stable address and data. They also assume that event pulses may coincide with writes to the same byte, since that is where the precedence of set over clear matters. The stimulus changes every input only on the falling clock edge and issues at most one write per cycle. It deliberately places an event and a clearing write in the same cycle for both the flag byte and the code byte. It holds tec_i and rec_i steady while their addresses are read.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int DATA_W = 8;
  localparam int FLAG_W = 8;
  localparam int CODE_W = 7;
  localparam int A_FLAG = 0;
  localparam int A_EN   = 1;
  localparam int A_CODE = 2;
  localparam int A_TEC  = 3;
  localparam int A_REC  = 4;
endpackage

// File: rtl/can_err_w0c_reg.sv
module can_err_w0c_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (evt_i[i]) q_o[i] <= 1'b1;  // set beats clear
      else if (wr_i && !wdata_i[i]) q_o[i] <= 1'b0;
    end
  end

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((q_o & $past(evt_i)) == $past(evt_i)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && evt_i == '0) |=> (q_o == $past(q_o)));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && evt_i == '0) |=> (q_o == ($past(q_o) & $past(wdata_i))));
  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (|evt_i)) |=> ((q_o & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/can_err_code_store.sv
module can_err_code_store #(
  parameter int CW = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [CW-1:0] evt_i,
  input  logic        wr_i,
  input  logic [CW:0] wdata_i,
  output logic [CW:0] q_o
);
  logic          accum;
  logic [CW-1:0] kept, nxt;

  assign accum = q_o[CW];
  assign kept  = wr_i ? (q_o[CW-1:0] & wdata_i[CW-1:0]) : q_o[CW-1:0];

  always_comb begin
    if (|evt_i) nxt = accum ? (kept | evt_i) : evt_i;
    else        nxt = kept;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else begin
      q_o[CW-1:0] <= nxt;
      if (wr_i) q_o[CW] <= wdata_i[CW];
    end
  end

  p_accum_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accum && (|evt_i) && !wr_i) |=> (q_o[CW-1:0] == ($past(q_o[CW-1:0]) | $past(evt_i))));
  p_latest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accum && (|evt_i)) |=> (q_o[CW-1:0] == $past(evt_i)));
  p_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q_o[CW] == $past(wdata_i[CW])));
  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (|evt_i)) |=> ((q_o[CW-1:0] & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/can_err_rd_mux.sv
module can_err_rd_mux
  import can_err_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] flag_i,
  input  logic [DATA_W-1:0] en_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic [DATA_W-1:0] tec_i,
  input  logic [DATA_W-1:0] rec_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if      (addr_i == AW'(A_FLAG)) data_o = flag_i;
    else if (addr_i == AW'(A_EN))   data_o = en_i;
    else if (addr_i == AW'(A_CODE)) data_o = code_i;
    else if (addr_i == AW'(A_TEC))  data_o = tec_i;
    else if (addr_i == AW'(A_REC))  data_o = rec_i;
  end
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
  import can_err_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] flag_evt_i,
  input  logic [CODE_W-1:0] code_evt_i,
  input  logic [DATA_W-1:0] tec_i,
  input  logic [DATA_W-1:0] rec_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              irq_en_i,
  output logic              err_stat_o,
  output logic              irq_o
);
  logic              wr_flag, wr_en, wr_code;
  logic [FLAG_W-1:0] flag_q, en_q;
  logic [CODE_W:0]   code_q;

  assign wr_flag = wr_en_i && (wr_addr_i == ADDR_W'(A_FLAG));
  assign wr_en   = wr_en_i && (wr_addr_i == ADDR_W'(A_EN));
  assign wr_code = wr_en_i && (wr_addr_i == ADDR_W'(A_CODE));

  can_err_w0c_reg #(.W(FLAG_W)) u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(flag_evt_i),
    .wr_i(wr_flag), .wdata_i(wr_data_i[FLAG_W-1:0]), .q_o(flag_q)
  );

  can_err_code_store #(.CW(CODE_W)) u_code (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(code_evt_i),
    .wr_i(wr_code), .wdata_i(wr_data_i[CODE_W:0]), .q_o(code_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (wr_en) en_q <= wr_data_i[FLAG_W-1:0];
  end

  assign err_stat_o = |(flag_q & en_q);
  assign irq_o      = err_stat_o & irq_en_i;

  can_err_rd_mux #(.AW(ADDR_W)) u_rd (
    .addr_i(rd_addr_i), .flag_i(DATA_W'(flag_q)), .en_i(DATA_W'(en_q)),
    .code_i(DATA_W'(code_q)), .tec_i(tec_i), .rec_i(rec_i), .data_o(rd_data_o)
  );

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && err_stat_o));
  p_en_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (en_q == $past(wr_data_i[FLAG_W-1:0])));
  p_ro_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= ADDR_W'(A_TEC) && flag_evt_i == '0 && code_evt_i == '0)
      |=> (en_q == $past(en_q) && flag_q == $past(flag_q) && code_q == $past(code_q)));
endmodule

// File: tb/sim_can_err_capture.sv
`timescale 1ns/1ps
module sim_can_err_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] flag_evt = '0;
  logic [6:0] code_evt = '0;
  logic [7:0] tec = '0, rec = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       irq_en = 1'b0, err_stat, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  can_err_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .flag_evt_i(flag_evt), .code_evt_i(code_evt),
    .tec_i(tec), .rec_i(rec), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_en_i(irq_en), .err_stat_o(err_stat), .irq_o(irq)
  );

  // kind 0: register read, 1: err_stat_o, 2: irq_o
  typedef struct { int kind; logic [2:0] addr; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  // monitor
  initial begin
    forever begin
      @(negedge clk); #2;
      if (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb[0];
        rd_addr = it.addr;
        #1;
        case (it.kind)
          0: act = rd_data;
          1: act = {7'd0, err_stat};
          default: act = {7'd0, irq};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h", it.tag, it.kind, it.addr, act, it.exp);
        end
        void'(sb.pop_front());
      end
    end
  end

  task automatic expect_item(int kind, logic [2:0] a, logic [7:0] e, string tag);
    item_t it;
    it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic cyc(logic we, logic [2:0] a, logic [7:0] d, logic [7:0] fe, logic [6:0] ce);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; flag_evt = fe; code_evt = ce;
    @(negedge clk);
    wr_en = 0; flag_evt = '0; code_evt = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_item(0, 0, 8'h00, "R1 flag");
    expect_item(0, 1, 8'h00, "R1 en");
    expect_item(0, 2, 8'h00, "R1 code");
    expect_item(1, 0, 8'h00, "R1 stat");
    expect_item(2, 0, 8'h00, "R1 irq");
    // R2 bus-off entry (bit 3)
    cyc(0, 0, 0, 8'h08, 0);
    expect_item(0, 0, 8'h08, "R2 set");
    expect_item(1, 0, 8'h00, "R5 stat masked");
    cyc(0, 0, 0, 8'h00, 0);
    expect_item(0, 0, 8'h08, "R2 sticky");
    // R5 enable
    cyc(1, 1, 8'h08, 0, 0);
    expect_item(0, 1, 8'h08, "R5 en rd");
    expect_item(1, 0, 8'h01, "R5 stat");
    expect_item(2, 0, 8'h00, "R6 irq gated off");
    irq_en = 1'b1;
    expect_item(2, 0, 8'h01, "R6 irq on");
    // R2 bus lock + bus error
    cyc(0, 0, 0, 8'h81, 0);
    expect_item(0, 0, 8'h89, "R2 multi");
    // R3 clear one bit via inverse mask
    cyc(1, 0, 8'hF7, 0, 0);
    expect_item(0, 0, 8'h81, "R3 clear");
    expect_item(1, 0, 8'h00, "R5 stat cleared");
    expect_item(2, 0, 8'h00, "R6 irq cleared");
    // R4 set wins over clear
    cyc(1, 0, 8'h00, 8'h01, 0);
    expect_item(0, 0, 8'h01, "R4 set wins");
    // R9 latest mode
    cyc(0, 0, 0, 0, 7'h08);
    expect_item(0, 2, 8'h08, "R9 crc");
    cyc(0, 0, 0, 0, 7'h01);
    expect_item(0, 2, 8'h01, "R9 replace");
    // R11 read-only / unmapped writes ignored
    tec = 8'h5A; rec = 8'hA5;
    cyc(1, 3, 8'hFF, 0, 0);
    cyc(1, 5, 8'h00, 0, 0);
    cyc(1, 7, 8'h00, 0, 0);
    expect_item(0, 0, 8'h01, "R11 flag kept");
    expect_item(0, 1, 8'h08, "R11 en kept");
    expect_item(0, 2, 8'h01, "R11 code kept");
    expect_item(0, 3, 8'h5A, "R11 tec");
    expect_item(0, 4, 8'hA5, "R11 rec");
    expect_item(0, 5, 8'h00, "R11 unmapped");
    // R7/R8 accumulate mode
    cyc(1, 2, 8'h80, 0, 0);
    expect_item(0, 2, 8'h80, "R7 mode set");
    cyc(0, 0, 0, 0, 7'h10);
    cyc(0, 0, 0, 0, 7'h02);
    expect_item(0, 2, 8'h92, "R8 accumulate");
    // R10 clear and set-wins
    cyc(1, 2, 8'hEF, 0, 0);
    expect_item(0, 2, 8'h82, "R10 clear");
    cyc(1, 2, 8'h80, 0, 7'h02);
    expect_item(0, 2, 8'h82, "R10 set wins");
    // R7 mode cleared, bits kept
    cyc(1, 2, 8'h7F, 0, 0);
    expect_item(0, 2, 8'h02, "R7 mode clear");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule